// File: doc/BRIEF.md
# NCO Phase Front End

This block is the control and phase-generation front of a direct digital synthesiser. A 34-bit input word passes through an input register that loads only while an active-low load strobe is asserted. The word is then decoded by two controls into one of four meanings: a full phase step, an absolute phase, a split word made of amplitude plus step, or a full-width step load. A 34-bit phase step register and a 34-bit phase accumulator follow. The top 16 accumulator bits leave the block as the phase word for a downstream sine/cosine stage, together with a 16-bit amplitude word and a flag that tells that stage whether to scale its outputs.

The jump and reset controls are registered with the data, so their effects line up with the input register. Any sample already in flight is finished before a discontinuity is applied. A step of zero holds the phase still, which produces DC at the output. The step may change on every clock with no double buffering, so frequency sweeps and frequency-shift keying need only a new word on each cycle.

Top module: `nco_phase_front`

## Requirements
- R1: The input register takes `din` on a rising edge when `load_n` is 0 and keeps its previous word when `load_n` is 1. The step and amplitude decode always acts on the held word.
- R2: A high `rst` sampled at edge r still lets edge r advance the accumulator by the old step. From edge r+1 on, the accumulator, the step register, the amplitude and `mul_en` are all 0.
- R3: With `mode_am`=0 and the effective jump at 0, the whole registered word becomes the step. At every edge the accumulator adds the previous step and wraps modulo 2^34. `phase` is accumulator bits 33:18.
- R4: With `mode_am`=0 and the effective jump at 1, the registered word replaces the accumulator at the next edge, and the step register keeps its value.
- R5: With `mode_am`=1 and the effective jump at 0, word bits 33:18 become the amplitude. Word bits 17:0 become step bits 33:16, and step bits 15:0 keep their value.
- R6: With `mode_am`=1 and the effective jump at 1, all 34 step bits load from the word and the amplitude keeps its value. The low 16 step bits then stay fixed until another such load or a reset.
- R7: The effective jump equals `jump` AND NOT `load_n`, so a `jump` raised while `load_n` is 1 has no effect.
- R8: With a step of zero, `phase` stays constant from cycle to cycle.
- R9: `phase_vld` is 0 from the edge after the first reset sample until one edge after `rst` is sampled low. After that it is 1 on every cycle.
- R10: `mul_en` equals the `mode_am` value sampled two edges earlier, and is 0 while the reset clear is in effect.
- R11: A step word presented at edge e is in the step register after edge e+1 and is first added to the accumulator at edge e+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, applied after the in-flight sample |
| load_n | input | 1 | Active-low load strobe for the input register |
| din | input | 34 | Step, phase or amplitude-plus-step word |
| mode_am | input | 1 | 1 selects split amplitude/step decode and output scaling |
| jump | input | 1 | Selects absolute phase (mode 0) or full-width step load (mode 1) |
| phase | output | 16 | Top accumulator bits for the sine/cosine stage |
| amp | output | 16 | Amplitude word for the output multipliers |
| mul_en | output | 1 | Tells the downstream stage to scale its outputs |
| phase_vld | output | 1 | A new phase sample is produced this cycle |

## Verification
The in-module properties rely on `rst` being held high across at least two rising edges at start-up, so the registered control word is defined before any property is armed. They also rely on the inputs being stable around each rising edge. The bench drives every input on the falling edge and starts with a three-cycle reset. Random resets later in the run are single-cycle pulses. The properties tolerate these because the delayed clear is itself a state the checks account for.

// File: rtl/nco_front_pkg.sv
package nco_front_pkg;

    parameter int unsigned ACC_W = 34;
    parameter int unsigned AMP_W = 16;
    parameter int unsigned PH_W  = 16;

    // low part of the word that feeds the top of the step in split mode
    localparam int unsigned INC_HI_W = ACC_W - AMP_W;

    typedef enum logic [1:0] {
        OP_INC_FULL  = 2'b00,
        OP_PHASE_SET = 2'b01,
        OP_INC_SPLIT = 2'b10,
        OP_INC_WIDE  = 2'b11
    } load_op_e;

    typedef struct packed {
        load_op_e op;
        logic     am;
        logic     clr;
    } ctl_t;

    function automatic load_op_e decode_op(input logic am, input logic jmp);
        return load_op_e'({am, jmp});
    endfunction

endpackage

// File: rtl/nco_load_reg.sv
module nco_load_reg
    import nco_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             mode_am,
    input  logic             jump,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] word_q,
    output ctl_t             ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            ctl_q.op  <= OP_INC_FULL;
            ctl_q.am  <= 1'b0;
            ctl_q.clr <= 1'b1;
        end else begin
            if (!load_n) begin
                word_q <= din;
            end
            ctl_q.op  <= decode_op(mode_am, jump & ~load_n);
            ctl_q.am  <= mode_am;
            ctl_q.clr <= 1'b0;
        end
    end

    assert_word_hold_R1: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(word_q));

    // a jump can only take effect together with a load
    assert_jump_gated_R7: assert property (@(posedge clk) disable iff (rst)
        load_n |=> (ctl_q.op != OP_PHASE_SET) && (ctl_q.op != OP_INC_WIDE));

endmodule

// File: rtl/nco_step_reg.sv
module nco_step_reg
    import nco_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] word,
    input  ctl_t             ctl,
    output logic [ACC_W-1:0] inc,
    output logic [AMP_W-1:0] amp,
    output logic             mul_en
);

    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            inc    <= '0;
            amp    <= '0;
            mul_en <= 1'b0;
        end else begin
            mul_en <= ctl.am;
            unique case (ctl.op)
                OP_INC_FULL:  inc <= word;
                OP_INC_WIDE:  inc <= word;
                OP_INC_SPLIT: begin
                    inc <= {word[INC_HI_W-1:0], inc[AMP_W-1:0]};
                    amp <= word[ACC_W-1 -: AMP_W];
                end
                default: ;
            endcase
        end
    end

    assert_low_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.op == OP_INC_SPLIT) |=> inc[AMP_W-1:0] == $past(inc[AMP_W-1:0]));

    assert_amp_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.op == OP_INC_WIDE) |=> $stable(amp));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (inc == '0) && (amp == '0) && !mul_en);

endmodule

// File: rtl/nco_accum.sv
module nco_accum
    import nco_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] word,
    input  ctl_t             ctl,
    input  logic [ACC_W-1:0] inc,
    output logic [PH_W-1:0]  phase,
    output logic             vld
);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            acc <= '0;
            vld <= 1'b0;
        end else begin
            vld <= 1'b1;
            if (ctl.op == OP_PHASE_SET) begin
                acc <= word;
            end else begin
                acc <= acc + inc;
            end
        end
    end

    assign phase = acc[ACC_W-1 -: PH_W];

    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.op != OP_PHASE_SET) |=> acc == ACC_W'($past(acc) + $past(inc)));

    assert_phase_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.op == OP_PHASE_SET) |=> acc == $past(word));

    assert_dc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.op != OP_PHASE_SET && inc == '0) |=> $stable(acc));

    assert_vld_low_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> !vld);

endmodule

// File: rtl/nco_phase_front.sv
module nco_phase_front
    import nco_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [ACC_W-1:0] din,
    input  logic             mode_am,
    input  logic             jump,
    output logic [PH_W-1:0]  phase,
    output logic [AMP_W-1:0] amp,
    output logic             mul_en,
    output logic             phase_vld
);

    logic [ACC_W-1:0] word_q;
    ctl_t             ctl_q;
    logic [ACC_W-1:0] inc;

    nco_load_reg u_load (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n),
        .mode_am (mode_am),
        .jump    (jump),
        .din     (din),
        .word_q  (word_q),
        .ctl_q   (ctl_q)
    );

    nco_step_reg u_step (
        .clk    (clk),
        .rst    (rst),
        .word   (word_q),
        .ctl    (ctl_q),
        .inc    (inc),
        .amp    (amp),
        .mul_en (mul_en)
    );

    nco_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .word  (word_q),
        .ctl   (ctl_q),
        .inc   (inc),
        .phase (phase),
        .vld   (phase_vld)
    );

    assert_mul_en_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ctl_q.clr) |=> mul_en == $past(mode_am, 2));

endmodule

// File: tb/sim_nco_phase_front.sv
module sim_nco_phase_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_n = 1'b0;
    logic [33:0] din = '0;
    logic        mode_am = 1'b0;
    logic        jump = 1'b0;
    logic [15:0] phase;
    logic [15:0] amp;
    logic        mul_en;
    logic        phase_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nco_phase_front u0 (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din),
        .mode_am(mode_am), .jump(jump),
        .phase(phase), .amp(amp), .mul_en(mul_en), .phase_vld(phase_vld)
    );

    // reference state, derived from the requirements
    logic [33:0] m_word = '0;
    logic        m_am = 1'b0, m_jmp = 1'b0, m_clr = 1'b1;
    logic [33:0] m_inc = '0, m_acc = '0;
    logic [15:0] m_amp = '0;
    logic        m_mul = 1'b0, m_vld = 1'b0;

    task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic r, input logic ln, input logic m,
                              input logic j, input logic [33:0] d);
        logic [33:0] n_inc, n_acc;
        logic [15:0] n_amp;
        logic        n_mul, n_vld;
        n_inc = m_inc; n_acc = m_acc; n_amp = m_amp;
        if (m_clr) begin
            n_inc = '0; n_acc = '0; n_amp = '0; n_mul = 1'b0; n_vld = 1'b0;
        end else begin
            n_mul = m_am; n_vld = 1'b1;
            case ({m_am, m_jmp})
                2'b00: begin n_inc = m_word; n_acc = m_acc + m_inc; end
                2'b01: n_acc = m_word;
                2'b10: begin
                    n_inc = {m_word[17:0], m_inc[15:0]};
                    n_amp = m_word[33:18];
                    n_acc = m_acc + m_inc;
                end
                default: begin n_inc = m_word; n_acc = m_acc + m_inc; end
            endcase
        end
        m_inc = n_inc; m_acc = n_acc; m_amp = n_amp; m_mul = n_mul; m_vld = n_vld;
        if (r) begin
            m_word = '0; m_am = 1'b0; m_jmp = 1'b0; m_clr = 1'b1;
        end else begin
            if (!ln) m_word = d;
            m_am = m; m_jmp = j & ~ln; m_clr = 1'b0;
        end
    endtask

    task automatic cyc(input logic r, input logic ln, input logic m, input logic j,
                       input logic [33:0] d, input string tag, input bit cmp);
        rst = r; load_n = ln; mode_am = m; jump = j; din = d;
        @(posedge clk);
        model_step(r, ln, m, j, d);
        @(negedge clk);
        if (cmp) begin
            chk({tag, " phase"}, {18'd0, phase}, {18'd0, m_acc[33:18]});
            chk({tag, " amp"}, {18'd0, amp}, {18'd0, m_amp});
            chk({"R10 mul_en ", tag}, {33'd0, mul_en}, {33'd0, m_mul});
            chk({"R9 vld ", tag}, {33'd0, phase_vld}, {33'd0, m_vld});
        end
    endtask

    localparam logic [33:0] STEP1 = 34'h0_0004_0000; // one phase LSB per clock

    initial begin
        logic [15:0] p0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(1, 0, 0, 0, '0, "R2", 0);
        cyc(1, 0, 0, 0, '0, "R2", 1);
        cyc(1, 0, 0, 0, '0, "R2", 1);
        chk("R2 reset phase", {18'd0, phase}, 34'd0);
        chk("R9 reset vld", {33'd0, phase_vld}, 34'd0);

        // R3 / R11: step of one phase LSB
        cyc(0, 0, 0, 0, STEP1, "R3", 1);
        chk("R9 first cycle after reset", {33'd0, phase_vld}, 34'd0);
        cyc(0, 0, 0, 0, STEP1, "R11", 1);
        cyc(0, 0, 0, 0, STEP1, "R11", 1);
        chk("R11 first step applied", {18'd0, phase}, 34'd1);
        for (int i = 0; i < 4; i++) begin
            p0 = phase;
            cyc(0, 0, 0, 0, STEP1, "R3", 1);
            chk("R3 phase +1", {18'd0, phase}, {18'd0, 16'(p0 + 16'd1)});
        end

        // R4: absolute phase to three quarters of a turn
        cyc(0, 0, 0, 1, 34'h3_0000_0000, "R4", 1);
        cyc(0, 0, 0, 0, STEP1, "R4", 1);
        chk("R4 absolute phase", {18'd0, phase}, 34'h0_0000_C000);
        cyc(0, 0, 0, 0, STEP1, "R4", 1);
        chk("R4 step kept", {18'd0, phase}, 34'h0_0000_C001);

        // R3 wrap
        cyc(0, 0, 0, 1, 34'h3_FFFF_0000, "R3", 1);
        cyc(0, 0, 0, 0, STEP1, "R3", 1);
        chk("R3 before wrap", {18'd0, phase}, 34'h0_0000_FFFF);
        cyc(0, 0, 0, 0, STEP1, "R3", 1);
        chk("R3 wrap to zero", {18'd0, phase}, 34'd0);

        // R8: zero step
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, '0, "R8", 1);
        p0 = phase;
        cyc(0, 0, 0, 0, '0, "R8", 1);
        cyc(0, 0, 0, 0, '0, "R8", 1);
        chk("R8 dc phase", {18'd0, phase}, {18'd0, p0});

        // R1: held word while din changes
        cyc(0, 0, 0, 0, STEP1, "R1", 1);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 34'h2_0000_0000 + 34'(i), "R1", 1);
        p0 = phase;
        cyc(0, 1, 0, 0, 34'h1_2345_6789, "R1", 1);
        chk("R1 held step", {18'd0, phase}, {18'd0, 16'(p0 + 16'd1)});

        // R7: jump without load strobe
        p0 = phase;
        cyc(0, 1, 0, 1, 34'h1_0000_0000, "R7", 1);
        cyc(0, 1, 0, 0, 34'h1_0000_0000, "R7", 1);
        chk("R7 jump ignored", {18'd0, phase}, {18'd0, 16'(p0 + 16'd2)});

        // R5: split word
        cyc(0, 0, 1, 0, {16'h1234, 18'h0_0001}, "R5", 1);
        cyc(0, 0, 1, 0, {16'h1234, 18'h0_0001}, "R5", 1);
        chk("R5 amp field", {18'd0, amp}, 34'h0_0000_1234);
        chk("R10 mul_en set", {33'd0, mul_en}, 34'd1);

        // R6: wide load, then split loads keep the low half
        cyc(0, 0, 1, 1, 34'h2_AAAA_5555, "R6", 1);
        cyc(0, 0, 1, 0, {16'h0777, 18'h0_0010}, "R6", 1);
        chk("R6 amp kept on wide load", {18'd0, amp}, 34'h0_0000_1234);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, {16'h0777, 18'(i)}, "R6", 1);

        // R2: reset while running, in-flight step still applied
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, STEP1, "R2", 1);
        p0 = phase;
        cyc(1, 0, 0, 0, STEP1, "R2", 1);
        chk("R2 in-flight sample", {18'd0, phase}, {18'd0, 16'(p0 + 16'd1)});
        cyc(0, 0, 0, 0, STEP1, "R2", 1);
        chk("R2 cleared", {18'd0, phase}, 34'd0);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [33:0] d;
            d = {$urandom, $urandom} [33:0];
            if ($urandom_range(0, 3) == 0) d = d & 34'h0_00FF_FFFF;
            cyc(($urandom_range(0, 99) == 0), ($urandom_range(0, 5) == 0),
                $urandom_range(0, 1) == 1, ($urandom_range(0, 7) == 0),
                d, "R3 random", 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule